// File: doc/BRIEF.md
# Collision-Arbitrated Dual-Port RAM

This block is a clocked true dual-port memory of 2048 words by 9 bits with a left and a right port. Both ports can reach every word. Each port has an enable, a write select, a read (output) enable, an 11-bit address, write data, read data and a write-inhibit input. The memory notices when both enabled ports name the same word. It then picks one of them and raises a registered busy flag toward the other. A write from the side that lost is dropped inside the block, so the loser cannot corrupt the word the winner is using.

A parameter picks one of two roles. In the arbitrating (master) role the block makes the collision decision itself and drives the busy outputs. In the following (slave) role the block does no arbitration: its busy outputs stay low, and each port's inhibit input alone blocks that port's writes. Several following slices can take their inhibits from one arbitrating slice, which makes the data word wider with a single, consistent decision. The inhibit inputs also block writes in the arbitrating role.

Top module: `dual_port_collide_ram`

## Requirements
- R1: Every one of the 2048 words, addresses 0x000 through 0x7FF, can be written and read from either port. A read sampled at clock edge N returns its word on that port's read data after edge N, so a word written by one port is returned to the other port on a later read.
- R2: A port with enable low neither writes nor reads. Enable high with write select high is a write. Enable high, write select low and read enable high is a read. Read data is zero after every edge that did not sample a read on that port, and it is zero after reset.
- R3: A collision is declared only from the two enables and the two addresses. Two reads of the same word collide just as writes do.
- R4: If one port has held its enable and address steady since the previous edge and the other port has just moved onto the same word, the steady port wins. If neither port or both ports qualify, the left port wins (parameter TIE_LEFT, default 1). The two busy outputs are never high together.
- R5: Once a collision has been granted, the same winner keeps the grant for as long as the two ports still match.
- R6: Busy is active high and registered. It rises after the edge that samples the losing request, and it falls after the first edge at which the addresses differ or either enable is low. Both busy outputs are low after reset.
- R7: A write is dropped, and memory keeps its old value, if the port loses the collision at that edge or if the port's busy output is high when that edge arrives.
- R8: When both ports write the same word at the same edge, only the winner's data is stored.
- R9: With the role parameter IS_MASTER = 0, the busy outputs stay low, no write is ever dropped for a collision, and a same-edge write of one word by both ports keeps the left port's data. A port whose inhibit input is high has its writes dropped.
- R10: With IS_MASTER = 1, a high inhibit input also drops that port's writes. A low inhibit input changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left write select (1 = write) |
| l_oe | input | 1 | Left read enable |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 9 | Left write data |
| l_inhibit | input | 1 | Left write inhibit |
| l_rdata | output | 9 | Left read data, registered |
| l_busy | output | 1 | Left lost a collision, registered |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right write select (1 = write) |
| r_oe | input | 1 | Right read enable |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 9 | Right write data |
| r_inhibit | input | 1 | Right write inhibit |
| r_rdata | output | 9 | Right read data, registered |
| r_busy | output | 1 | Right lost a collision, registered |

## Verification
The hardest case to reach from the ports is a collision that is decided by order of arrival rather than by the tie rule. The stimulus has to park one port on a word for at least one edge and then move the other port onto that same word. This is done in both directions. A write is then issued from the losing side while its busy output is high, and the word is read back after the collision clears, which shows that the dropped write left memory unchanged. Same-edge double writes and the inhibit paths are driven on both an arbitrating and a following instance fed by the same stimulus.

// File: rtl/dpcr_pkg.sv
package dpcr_pkg;
    localparam int PORTS = 2;
    localparam int LP    = 0;
    localparam int RP    = 1;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/dpcr_arbiter.sv
module dpcr_arbiter
    import dpcr_pkg::*;
#(
    parameter int AW       = 11,
    parameter bit TIE_LEFT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_en,
    input  logic [AW-1:0] l_addr,
    input  logic          r_en,
    input  logic [AW-1:0] r_addr,
    output logic          l_lose,
    output logic          r_lose,
    output logic          l_busy,
    output logic          r_busy
);
    typedef struct packed {
        owner_e        owner;
        logic          l_busy;
        logic          r_busy;
        logic          l_seen;
        logic [AW-1:0] l_last;
        logic          r_seen;
        logic [AW-1:0] r_last;
    } arb_t;

    arb_t s_d, s_q;
    logic match;
    logic l_held;
    logic r_held;
    logic pick_left;

    always_comb begin
        match  = l_en && r_en && (l_addr == r_addr);
        // a port is "held" if it was enabled on this same word last cycle
        l_held = s_q.l_seen && (s_q.l_last == l_addr);
        r_held = s_q.r_seen && (s_q.r_last == r_addr);
        if (l_held && !r_held) begin
            pick_left = 1'b1;
        end else if (r_held && !l_held) begin
            pick_left = 1'b0;
        end else begin
            pick_left = TIE_LEFT;
        end

        s_d        = s_q;
        s_d.l_seen = l_en;
        s_d.l_last = l_addr;
        s_d.r_seen = r_en;
        s_d.r_last = r_addr;

        if (!match) begin
            s_d.owner = OWN_NONE;
        end else if (s_q.owner == OWN_NONE) begin
            s_d.owner = pick_left ? OWN_LEFT : OWN_RIGHT;
        end

        l_lose     = match && (s_d.owner == OWN_RIGHT);
        r_lose     = match && (s_d.owner == OWN_LEFT);
        s_d.l_busy = l_lose;
        s_d.r_busy = r_lose;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign l_busy = s_q.l_busy;
    assign r_busy = s_q.r_busy;

    // R4: only one side may ever see busy
    p_never_both_r4: assert property (@(posedge clk) disable iff (rst)
        !(l_busy && r_busy));

    // R4: a port already parked on the word beats a newcomer
    p_earlier_left_r4: assert property (@(posedge clk) disable iff (rst)
        (match && s_q.owner == OWN_NONE && l_held && !r_held) |=> r_busy);

    p_earlier_right_r4: assert property (@(posedge clk) disable iff (rst)
        (match && s_q.owner == OWN_NONE && r_held && !l_held) |=> l_busy);

    // R5: the grant does not flip while the collision lasts
    p_grant_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (r_busy && match) |=> r_busy);

    p_grant_kept_l_r5: assert property (@(posedge clk) disable iff (rst)
        (l_busy && match) |=> l_busy);

    // R6: busy drops once the ports no longer match
    p_busy_clears_r6: assert property (@(posedge clk) disable iff (rst)
        !match |=> (!l_busy && !r_busy));
endmodule

// File: rtl/dpcr_bank.sv
module dpcr_bank #(
    parameter int AW = 11,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_we,
    input  logic          l_re,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wd,
    output logic [DW-1:0] l_rd,
    input  logic          r_we,
    input  logic          r_re,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wd,
    output logic [DW-1:0] r_rd
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] l;
        logic [DW-1:0] r;
    } rd_t;

    logic [DW-1:0] mem [DEPTH];
    rd_t rd_d, rd_q;

    always_comb begin
        rd_d   = rd_q;
        rd_d.l = l_re ? mem[l_addr] : '0;
        rd_d.r = r_re ? mem[r_addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    // left is written last so it wins a same-word double write
    always_ff @(posedge clk) begin
        if (r_we) begin
            mem[r_addr] <= r_wd;
        end
        if (l_we) begin
            mem[l_addr] <= l_wd;
        end
    end

    assign l_rd = rd_q.l;
    assign r_rd = rd_q.r;

    // R2: an edge without a read leaves the read data at zero
    p_quiet_l_r2: assert property (@(posedge clk) disable iff (rst)
        !l_re |=> (l_rd == '0));

    p_quiet_r_r2: assert property (@(posedge clk) disable iff (rst)
        !r_re |=> (r_rd == '0));
endmodule

// File: rtl/dpcr_port_gate.sv
module dpcr_port_gate (
    input  logic en,
    input  logic wr,
    input  logic oe,
    input  logic lose,
    input  logic busy,
    input  logic inhibit,
    output logic we,
    output logic re
);
    logic blocked;

    always_comb begin
        blocked = lose || busy || inhibit;
        we      = en && wr && !blocked;
        re      = en && !wr && oe;
    end
endmodule

// File: rtl/dual_port_collide_ram.sv
module dual_port_collide_ram
    import dpcr_pkg::*;
#(
    parameter int AW        = 11,
    parameter int DW        = 9,
    parameter bit IS_MASTER = 1'b1,
    parameter bit TIE_LEFT  = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_en,
    input  logic          l_wr,
    input  logic          l_oe,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    input  logic          l_inhibit,
    output logic [DW-1:0] l_rdata,
    output logic          l_busy,
    input  logic          r_en,
    input  logic          r_wr,
    input  logic          r_oe,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    input  logic          r_inhibit,
    output logic [DW-1:0] r_rdata,
    output logic          r_busy
);
    logic [PORTS-1:0] en_v, wr_v, oe_v, inh_v;
    logic [PORTS-1:0] lose_v, busy_v, we_v, re_v;

    assign en_v  = {r_en, l_en};
    assign wr_v  = {r_wr, l_wr};
    assign oe_v  = {r_oe, l_oe};
    assign inh_v = {r_inhibit, l_inhibit};

    generate
        if (IS_MASTER) begin : g_arb
            logic l_lose_w, r_lose_w, l_busy_w, r_busy_w;
            dpcr_arbiter #(
                .AW       (AW),
                .TIE_LEFT (TIE_LEFT)
            ) u_arb (
                .clk    (clk),
                .rst    (rst),
                .l_en   (l_en),
                .l_addr (l_addr),
                .r_en   (r_en),
                .r_addr (r_addr),
                .l_lose (l_lose_w),
                .r_lose (r_lose_w),
                .l_busy (l_busy_w),
                .r_busy (r_busy_w)
            );
            assign lose_v = {r_lose_w, l_lose_w};
            assign busy_v = {r_busy_w, l_busy_w};
        end else begin : g_follow
            assign lose_v = '0;
            assign busy_v = '0;
        end
    endgenerate

    generate
        for (genvar g = 0; g < PORTS; g++) begin : g_port
            dpcr_port_gate u_gate (
                .en      (en_v[g]),
                .wr      (wr_v[g]),
                .oe      (oe_v[g]),
                .lose    (lose_v[g]),
                .busy    (busy_v[g]),
                .inhibit (inh_v[g]),
                .we      (we_v[g]),
                .re      (re_v[g])
            );

            // R7: nothing reaches memory from a port showing busy
            p_no_write_busy_r7: assert property (@(posedge clk) disable iff (rst)
                busy_v[g] |-> !we_v[g]);

            // R10: an inhibited port never writes
            p_inhibit_holds_r10: assert property (@(posedge clk) disable iff (rst)
                inh_v[g] |-> !we_v[g]);
        end
    endgenerate

    dpcr_bank #(
        .AW (AW),
        .DW (DW)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .l_we   (we_v[LP]),
        .l_re   (re_v[LP]),
        .l_addr (l_addr),
        .l_wd   (l_wdata),
        .l_rd   (l_rdata),
        .r_we   (we_v[RP]),
        .r_re   (re_v[RP]),
        .r_addr (r_addr),
        .r_wd   (r_wdata),
        .r_rd   (r_rdata)
    );

    assign l_busy = busy_v[LP];
    assign r_busy = busy_v[RP];

    // R8: with a collision on the word, both ports never write together
    p_single_writer_r8: assert property (@(posedge clk) disable iff (rst)
        (IS_MASTER && l_en && r_en && l_addr == r_addr) |-> !(we_v[LP] && we_v[RP]));
endmodule

// File: tb/sim_dual_port_collide_ram.sv
`timescale 1ns/1ps
module sim_dual_port_collide_ram;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        l_en = 0, l_wr = 0, l_oe = 0, r_en = 0, r_wr = 0, r_oe = 0;
    logic [10:0] l_addr = '0, r_addr = '0;
    logic [8:0]  l_wd = '0, r_wd = '0;
    logic        l_inh0 = 0, r_inh0 = 0, l_inh1 = 0, r_inh1 = 0;
    logic [8:0]  l_rd0, r_rd0, l_rd1, r_rd1;
    logic        l_bz0, r_bz0, l_bz1, r_bz1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    dual_port_collide_ram #(.IS_MASTER(1'b1)) u0 (
        .clk(clk), .rst(rst),
        .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wd),
        .l_inhibit(l_inh0), .l_rdata(l_rd0), .l_busy(l_bz0),
        .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wd),
        .r_inhibit(r_inh0), .r_rdata(r_rd0), .r_busy(r_bz0)
    );

    dual_port_collide_ram #(.IS_MASTER(1'b0)) u1 (
        .clk(clk), .rst(rst),
        .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wd),
        .l_inhibit(l_inh1), .l_rdata(l_rd1), .l_busy(l_bz1),
        .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wd),
        .r_inhibit(r_inh1), .r_rdata(r_rd1), .r_busy(r_bz1)
    );

    // row: {L en,wr,oe,addr,wd, R en,wr,oe,addr,wd, exp Lbusy,Rbusy,Lrd,Rrd}
    localparam int NROW = 16;
    localparam logic [65:0] VEC [0:NROW-1] = '{
        {1'b1,1'b1,1'b0,11'h010,9'h1A5, 1'b0,1'b0,1'b0,11'h000,9'h000, 1'b0,1'b0,9'h000,9'h000},
        {1'b0,1'b0,1'b0,11'h000,9'h000, 1'b1,1'b1,1'b0,11'h7FF,9'h0C3, 1'b0,1'b0,9'h000,9'h000},
        {1'b1,1'b0,1'b1,11'h7FF,9'h000, 1'b1,1'b0,1'b1,11'h010,9'h000, 1'b0,1'b0,9'h0C3,9'h1A5},
        {1'b1,1'b1,1'b0,11'h100,9'h055, 1'b1,1'b1,1'b0,11'h100,9'h0AA, 1'b0,1'b1,9'h000,9'h000},
        {1'b1,1'b0,1'b1,11'h100,9'h000, 1'b1,1'b0,1'b1,11'h100,9'h000, 1'b0,1'b1,9'h055,9'h055},
        {1'b1,1'b0,1'b1,11'h100,9'h000, 1'b1,1'b1,1'b0,11'h100,9'h111, 1'b0,1'b1,9'h055,9'h000},
        {1'b0,1'b0,1'b0,11'h000,9'h000, 1'b1,1'b0,1'b1,11'h100,9'h000, 1'b0,1'b0,9'h000,9'h055},
        {1'b0,1'b0,1'b0,11'h000,9'h000, 1'b1,1'b1,1'b0,11'h100,9'h111, 1'b0,1'b0,9'h000,9'h000},
        {1'b1,1'b0,1'b1,11'h100,9'h000, 1'b1,1'b0,1'b1,11'h100,9'h000, 1'b1,1'b0,9'h111,9'h111},
        {1'b1,1'b1,1'b0,11'h100,9'h1FF, 1'b1,1'b0,1'b1,11'h100,9'h000, 1'b1,1'b0,9'h000,9'h111},
        {1'b1,1'b0,1'b1,11'h100,9'h000, 1'b0,1'b0,1'b0,11'h000,9'h000, 1'b0,1'b0,9'h111,9'h000},
        {1'b1,1'b0,1'b1,11'h100,9'h000, 1'b1,1'b1,1'b0,11'h100,9'h000, 1'b0,1'b1,9'h111,9'h000},
        {1'b1,1'b0,1'b1,11'h100,9'h000, 1'b0,1'b0,1'b0,11'h000,9'h000, 1'b0,1'b0,9'h111,9'h000},
        {1'b1,1'b0,1'b1,11'h7FF,9'h000, 1'b1,1'b0,1'b1,11'h010,9'h000, 1'b0,1'b0,9'h0C3,9'h1A5},
        {1'b1,1'b0,1'b0,11'h010,9'h000, 1'b0,1'b1,1'b0,11'h010,9'h000, 1'b0,1'b0,9'h000,9'h000},
        {1'b1,1'b0,1'b1,11'h010,9'h000, 1'b0,1'b0,1'b0,11'h000,9'h000, 1'b0,1'b0,9'h1A5,9'h000}
    };

    function automatic string row_req(int i);
        case (i)
            3:       return "R8";
            4:       return "R5";
            5, 9:    return "R7";
            6, 10:   return "R6";
            8:       return "R3";
            11, 12:  return "R4";
            14, 15:  return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [8:0] act, logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic le, logic lw, logic lo, logic [10:0] la, logic [8:0] ld,
                         logic re, logic rw, logic ro, logic [10:0] ra, logic [8:0] rd);
        l_en = le; l_wr = lw; l_oe = lo; l_addr = la; l_wd = ld;
        r_en = re; r_wr = rw; r_oe = ro; r_addr = ra; r_wd = rd;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // reset state: R2 and R6
        chk("R6", "reset u0 l_busy", {8'd0, l_bz0}, 9'd0);
        chk("R6", "reset u0 r_busy", {8'd0, r_bz0}, 9'd0);
        chk("R2", "reset u0 l_rdata", l_rd0, 9'd0);
        chk("R2", "reset u1 r_rdata", r_rd1, 9'd0);

        for (int i = 0; i < NROW; i++) begin
            logic [65:0] v;
            v = VEC[i];
            drive(v[65], v[64], v[63], v[62:52], v[51:43],
                  v[42], v[41], v[40], v[39:29], v[28:20]);
            chk(row_req(i), $sformatf("row %0d l_busy", i), {8'd0, l_bz0}, {8'd0, v[19]});
            chk(row_req(i), $sformatf("row %0d r_busy", i), {8'd0, r_bz0}, {8'd0, v[18]});
            chk(row_req(i), $sformatf("row %0d l_rdata", i), l_rd0, v[17:9]);
            chk(row_req(i), $sformatf("row %0d r_rdata", i), r_rd0, v[8:0]);
        end

        // R9: following slice, same-word double write keeps left data
        drive(1, 1, 0, 11'h055, 9'h123, 1, 1, 0, 11'h055, 9'h0EE);
        chk("R9", "u1 l_busy stays low", {8'd0, l_bz1}, 9'd0);
        chk("R9", "u1 r_busy stays low", {8'd0, r_bz1}, 9'd0);
        drive(1, 0, 1, 11'h055, 9'h000, 1, 0, 1, 11'h055, 9'h000);
        chk("R9", "u1 l_rdata after double write", l_rd1, 9'h123);
        chk("R9", "u1 r_rdata after double write", r_rd1, 9'h123);
        chk("R9", "u1 r_busy during collision", {8'd0, r_bz1}, 9'd0);

        // R9: inhibit on the following slice
        drive(0, 0, 0, 11'h000, 9'h000, 1, 1, 0, 11'h066, 9'h011);
        r_inh1 = 1'b1;
        drive(0, 0, 0, 11'h000, 9'h000, 1, 1, 0, 11'h066, 9'h0AB);
        r_inh1 = 1'b0;
        drive(0, 0, 0, 11'h000, 9'h000, 1, 0, 1, 11'h066, 9'h000);
        chk("R9", "u1 inhibited write dropped", r_rd1, 9'h011);

        // R10: inhibit on the arbitrating slice
        drive(1, 1, 0, 11'h088, 9'h022, 0, 0, 0, 11'h000, 9'h000);
        l_inh0 = 1'b1;
        drive(1, 1, 0, 11'h088, 9'h133, 0, 0, 0, 11'h000, 9'h000);
        l_inh0 = 1'b0;
        drive(1, 0, 1, 11'h088, 9'h000, 0, 0, 0, 11'h000, 9'h000);
        chk("R10", "u0 inhibited write dropped", l_rd0, 9'h022);
        chk("R10", "u1 same write without inhibit", l_rd1, 9'h133);
        drive(1, 1, 0, 11'h7FF, 9'h0F0, 0, 0, 0, 11'h000, 9'h000);
        drive(0, 0, 0, 11'h000, 9'h000, 1, 0, 1, 11'h7FF, 9'h000);
        chk("R10", "u0 write with inhibit low", r_rd0, 9'h0F0);

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule